// File: doc/BRIEF.md
# Reference-Domain Clock Presence Monitor

This block watches a clock that arrives from outside the chip and decides, using only a local reference clock, whether that clock is running. The monitored clock is brought into the reference domain through a flop synchronizer. Each rising edge seen after synchronization restarts a window counter. If a whole window of reference cycles goes by with no detected edge, the monitored clock is declared absent.

The result is shown on a registered availability flag. When the flag goes from available to absent, an interrupt indication is latched and held until software clears it. A mask input hides the indication from the interrupt line without erasing it, so unmasking shows any loss that happened while the mask was set. The window length (64 reference cycles by default) and the synchronizer depth are parameters.

Top module: `clk_presence_mon`

## Requirements
- R1: After a synchronous reset, or on any cycle while reset is high, `clk_avail` reads 0, `irq` reads 0 and no interrupt is pending.
- R2: Once available, `clk_avail` goes to 0 on the 64th consecutive reference cycle in which no synchronized rising edge is detected. Rising edges spaced 64 reference cycles apart or closer keep it at 1.
- R3: `mon_clk` passes through a two-flop synchronizer followed by an edge detector. A rising level sampled at reference edge n sets `clk_avail` to 1 after reference edge n+2, whatever its previous value.
- R4: A change of `clk_avail` from 1 to 0 sets the pending interrupt in the same cycle, so `irq` rises with the fall of `clk_avail` when unmasked. A change from 0 to 1 sets nothing.
- R5: A pending interrupt stays set until `irq_clr` is sampled high. When a new loss and a clear fall in the same cycle, the loss wins and the interrupt stays pending.
- R6: `irq` is a register loaded with pending AND NOT `irq_mask`. A high `irq_mask` forces `irq` low one cycle later. The mask does not change the pending state, so `irq` returns after unmasking.
- R7: Sampling `irq_clr` high with no new loss in that cycle clears the pending interrupt, and `irq` reads 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Local reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Monitored clock, asynchronous to clk_ref |
| irq_mask | input | 1 | 1 hides the pending interrupt from irq |
| irq_clr | input | 1 | Clears the pending interrupt when sampled high |
| clk_avail | output | 1 | 1 while the monitored clock is seen as present |
| irq | output | 1 | Masked interrupt line, registered |

## Verification
Two functions can act in the same cycle: a new loss that sets the pending bit, and a software clear that removes it. The bench holds `irq_clr` high across a loss of the monitored clock, so the set and the clear meet on the very cycle the window expires. The bench passes only if `irq` is high for exactly that one cycle, then low while the clear is still held. Window boundaries are exercised with edge spacings of exactly 64 cycles, which must hold availability, and of 66 cycles, which must drop it. A per-cycle behavioural model judges both the availability flag and the interrupt line.

// File: rtl/clk_presence_pkg.sv
`timescale 1ns/1ps
package clk_presence_pkg;
  // Reference cycles without an edge before the clock is declared absent
  parameter int unsigned CPM_WINDOW      = 64;
  // Depth of the synchronizer in front of the edge detector
  parameter int unsigned CPM_SYNC_STAGES = 2;

  function automatic int unsigned cpm_cnt_width(input int unsigned win);
    return (win < 2) ? 1 : $clog2(win);
  endfunction
endpackage

// File: rtl/cpm_sync_edge.sv
`timescale 1ns/1ps
module cpm_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] stage_q;
  logic              last_q;

  // Synchronizer chain: stage 0 captures the asynchronous level
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= 1'b0;
        else     stage_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= 1'b0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= stage_q[STAGES-1];
  end

  assign rise_o = stage_q[STAGES-1] & ~last_q;

  // R3: a detected rise is followed by a low-to-high history, never two rises in a row
  assert_no_double_rise_R3: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cpm_window.sv
`timescale 1ns/1ps
module cpm_window
  import clk_presence_pkg::*;
#(
  parameter int unsigned WINDOW = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  output logic avail_o,
  output logic loss_o
);
  localparam int unsigned CW = cpm_cnt_width(WINDOW);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] idle_q;   // reference cycles since the last detected rise
  logic          avail_q;
  logic          expire;

  assign expire = ~rise_i & (idle_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q  <= LAST;
      avail_q <= 1'b0;
    end else if (rise_i) begin
      idle_q  <= '0;
      avail_q <= 1'b1;
    end else if (expire) begin
      avail_q <= 1'b0;
    end else begin
      idle_q  <= idle_q + 1'b1;
    end
  end

  assign avail_o = avail_q;
  assign loss_o  = avail_q & expire;

  // R3: any detected rise makes the clock available on the next edge
  assert_rise_sets_avail_R3: assert property (@(posedge clk) disable iff (rst)
    rise_i |=> avail_q);
  // R2: availability is never lost before the window has run out
  assert_no_early_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (avail_q && !rise_i && idle_q != LAST) |=> avail_q);
  // R2: no rise keeps an absent clock absent
  assert_absent_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!avail_q && !rise_i) |=> !avail_q);
endmodule

// File: rtl/cpm_irq.sv
`timescale 1ns/1ps
module cpm_irq (
  input  logic clk,
  input  logic rst,
  input  logic loss_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic irq_o
);
  logic pend_q;
  logic pend_d;
  logic irq_q;

  // A new loss beats a clear arriving in the same cycle
  assign pend_d = loss_i | (pend_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= pend_d & ~mask_i;
    end
  end

  assign irq_o = irq_q;

  assert_loss_sets_R4: assert property (@(posedge clk) disable iff (rst)
    loss_i |=> pend_q);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr_i) |=> pend_q);
  assert_mask_hides_R6: assert property (@(posedge clk) disable iff (rst)
    mask_i |=> !irq_q);
  assert_clear_works_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !loss_i) |=> (!pend_q && !irq_q));
endmodule

// File: rtl/clk_presence_mon.sv
`timescale 1ns/1ps
module clk_presence_mon
  import clk_presence_pkg::*;
#(
  parameter int unsigned WINDOW      = CPM_WINDOW,
  parameter int unsigned SYNC_STAGES = CPM_SYNC_STAGES
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic mon_clk,
  input  logic irq_mask,
  input  logic irq_clr,
  output logic clk_avail,
  output logic irq
);
  logic rise;
  logic loss;

  cpm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_ref), .rst(rst), .async_i(mon_clk), .rise_o(rise)
  );

  cpm_window #(.WINDOW(WINDOW)) u_window (
    .clk(clk_ref), .rst(rst), .rise_i(rise), .avail_o(clk_avail), .loss_o(loss)
  );

  cpm_irq u_irq (
    .clk(clk_ref), .rst(rst), .loss_i(loss), .mask_i(irq_mask),
    .clr_i(irq_clr), .irq_o(irq)
  );

  // R1: outputs are quiet in the cycle after a reset cycle
  always_ff @(posedge clk_ref) begin
    if (!rst && $past(rst)) begin
      assert_reset_quiet_R1: assert (!clk_avail && !irq);
    end
  end
endmodule

// File: tb/clk_presence_mon_tb_top.sv
`timescale 1ns/1ps
module clk_presence_mon_tb_top;
  logic clk_ref = 1'b0;
  logic rst = 1'b1;
  logic mon_clk = 1'b0;
  logic irq_mask = 1'b0;
  logic irq_clr = 1'b0;
  logic clk_avail;
  logic irq;

  int n_checks = 0;
  int n_fail = 0;
  string cur_tag = "R1";

  always #10 clk_ref = ~clk_ref;

  clk_presence_mon dut_i (
    .clk_ref(clk_ref), .rst(rst), .mon_clk(mon_clk), .irq_mask(irq_mask),
    .irq_clr(irq_clr), .clk_avail(clk_avail), .irq(irq)
  );

  // Behavioural reference model, updated at every rising reference edge
  bit lv[$];
  int since;
  bit m_avail, m_pend, m_irq;

  always @(posedge clk_ref) begin
    bit det, lost;
    if (rst) begin
      lv = '{1'b0, 1'b0, 1'b0};
      since = 1000;
      m_avail = 0; m_pend = 0; m_irq = 0;
    end else begin
      det = lv[1] && !lv[2];
      if (det) since = 0; else since++;
      lost = m_avail && !det && since >= 64;
      if (det) m_avail = 1; else if (since >= 64) m_avail = 0;
      m_pend = lost || (m_pend && !irq_clr);
      m_irq = m_pend && !irq_mask;
      lv.push_front(mon_clk);
      void'(lv.pop_back());
    end
  end

  task automatic check(input bit act, input bit exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0b expected=%0b at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk_ref) begin
    if (!rst) begin
      check(clk_avail, m_avail, "clk_avail vs model");
      check(irq, m_irq, "irq vs model");
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic mon_run(input int half, input int periods);
    for (int i = 0; i < periods; i++) begin
      mon_clk = 1'b1; cycles(half);
      mon_clk = 1'b0; cycles(half);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    int highs;
    cycles(4);
    rst = 1'b0;
    cycles(1);
    cur_tag = "R1";
    check(clk_avail, 1'b0, "avail after reset");
    check(irq, 1'b0, "irq after reset");

    cur_tag = "R3";
    mon_run(5, 20);
    check(clk_avail, 1'b1, "available with fast clock");
    check(irq, 1'b0, "no irq on becoming available");

    cur_tag = "R2";
    mon_run(32, 6);
    check(clk_avail, 1'b1, "spacing of 64 keeps available");

    cur_tag = "R4";
    mon_clk = 1'b1;
    cycles(80);
    check(clk_avail, 1'b0, "absent after stop");
    check(irq, 1'b1, "irq on loss");
    cur_tag = "R5";
    cycles(20);
    check(irq, 1'b1, "irq sticky");

    cur_tag = "R6";
    irq_mask = 1'b1; cycles(2);
    check(irq, 1'b0, "masked irq low");
    irq_mask = 1'b0; cycles(2);
    check(irq, 1'b1, "pending kept under mask");

    cur_tag = "R7";
    irq_clr = 1'b1; cycles(1);
    irq_clr = 1'b0; cycles(1);
    check(irq, 1'b0, "cleared irq");

    cur_tag = "R4";
    mon_clk = 1'b0;
    mon_run(5, 10);
    check(clk_avail, 1'b1, "available again");
    check(irq, 1'b0, "no irq on recovery");

    cur_tag = "R2";
    mon_run(33, 4);
    check(irq, 1'b1, "spacing of 66 drops availability");
    irq_clr = 1'b1; cycles(1); irq_clr = 1'b0; cycles(1);

    cur_tag = "R5";
    mon_run(5, 6);
    irq_clr = 1'b1;
    highs = 0;
    for (int i = 0; i < 90; i++) begin
      cycles(1);
      if (irq) highs++;
    end
    check(highs == 1, 1'b1, "loss beats held clear for one cycle");
    irq_clr = 1'b0;
    cycles(2);
    check(irq, 1'b0, "clear held after the loss");

    cur_tag = "R1";
    mon_run(5, 6);
    rst = 1'b1; cycles(2);
    check(clk_avail, 1'b0, "avail during reset");
    check(irq, 1'b0, "irq during reset");
    rst = 1'b0; cycles(1);
    check(clk_avail, 1'b0, "avail after mid-run reset");
    cycles(3);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end
endmodule